// File: doc/BRIEF.md
# Configurable D/T Register Bank with Clear, Set and Load Controls

This block is a register of parameterized width that is elaborated either as a bank of data flip-flops or as a bank of toggle flip-flops. In data mode each input bit becomes the next state of its flip-flop. In toggle mode each input bit is a per-bit toggle enable.

Asynchronous controls act on the output in the same cycle they are asserted, without waiting for a clock. There are three of them: clear, set and load. Synchronous controls act only at a rising clock edge while the clock enable is high. There are also three of them: clear, set and load. The asynchronous set and the synchronous set each have their own preset constant. A separate flag parameter for each one selects between that constant and an all-ones fallback.

Both control groups resolve conflicts with the same fixed priority. Clear beats set, and set beats load. Any active asynchronous control overrides every clocked behaviour. A chip-level active-low reset clears the stored state. Controls that a design does not use are tied to their inactive values; the clock enable is tied high.

Top module: `ctl_reg_bank`

## Requirements
- R1: In data mode (KIND = FF_D), with enable high and no control active, q takes the value of d at the rising edge.
- R2: In toggle mode (KIND = FF_T), with enable high and no control active, each q bit inverts at the rising edge where its d bit is 1 and holds where it is 0.
- R3: With enable low and no asynchronous control active, q holds across the edge whatever the synchronous clear, set and load inputs are.
- R4: Synchronous clear with enable high sets q to all zeros at the edge, and it overrides synchronous set, synchronous load and the data/toggle operation.
- R5: Synchronous set with enable high loads SSET_VAL when SSET_HAS_VAL is 1, or all ones when it is 0, and it overrides synchronous load.
- R6: Synchronous load with enable high copies d into q at the edge in both modes. In toggle mode this means a load, not a toggle.
- R7: Asynchronous clear forces q to all zeros without a clock edge, and it overrides asynchronous set and asynchronous load.
- R8: Asynchronous set forces q to ASET_VAL when ASET_HAS_VAL is 1, or to all ones when it is 0, without a clock edge, and it overrides asynchronous load.
- R9: Asynchronous load makes q equal to d without a clock edge.
- R10: An active asynchronous control overrides enable and all synchronous controls. The value it forces is kept after release if the control was held across a rising edge.
- R11: While rst_ni is low, q is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the stored state |
| en_i | input | 1 | Clock enable for all synchronous behaviour |
| d_i | input | WIDTH | Data input (data mode) or per-bit toggle enable (toggle mode) |
| aclr_i | input | 1 | Asynchronous clear |
| aset_i | input | 1 | Asynchronous set to the async preset |
| aload_i | input | 1 | Asynchronous load of d_i |
| sclr_i | input | 1 | Synchronous clear |
| sset_i | input | 1 | Synchronous set to the sync preset |
| sload_i | input | 1 | Synchronous load of d_i |
| q_o | output | WIDTH | Register output |

## Verification
The clocked assertions sample the asynchronous controls only at rising edges. They therefore assume that any asynchronous pulse whose effect must persist is held across at least one edge; a pulse that begins and ends between edges is outside their scope. The stimulus changes all inputs only on falling edges. Every asynchronous assertion stays high through the following rising edge, so the retention rule and the edge-sampled properties both apply. Every pairwise conflict between the controls is driven on a data-mode instance with explicit preset constants and on a toggle-mode instance using the all-ones fallback. Random toggle masks are compared against a bench-side model.

// File: rtl/ctl_reg_pkg.sv
package ctl_reg_pkg;
  typedef enum logic {
    FF_D = 1'b0,
    FF_T = 1'b1
  } ff_kind_e;
endpackage

// File: rtl/ctl_reg_async.sv
module ctl_reg_async #(
  parameter int unsigned       WIDTH        = 8,
  parameter bit                ASET_HAS_VAL = 1'b0,
  parameter logic [WIDTH-1:0]  ASET_VAL     = '0
) (
  input  logic             aclr_i,
  input  logic             aset_i,
  input  logic             aload_i,
  input  logic [WIDTH-1:0] d_i,
  output logic             active_o,
  output logic [WIDTH-1:0] val_o
);
  logic [WIDTH-1:0] preset;

  generate
    if (ASET_HAS_VAL) begin : g_const
      assign preset = ASET_VAL;
    end else begin : g_ones
      assign preset = '1;
    end
  endgenerate

  assign active_o = aclr_i | aset_i | aload_i;

  // clear > set > load
  always_comb begin
    if (aclr_i)      val_o = '0;
    else if (aset_i) val_o = preset;
    else             val_o = d_i;
  end
endmodule

// File: rtl/ctl_reg_next.sv
module ctl_reg_next
  import ctl_reg_pkg::*;
#(
  parameter int unsigned       WIDTH        = 8,
  parameter ff_kind_e          KIND         = FF_D,
  parameter bit                SSET_HAS_VAL = 1'b0,
  parameter logic [WIDTH-1:0]  SSET_VAL     = '0
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic [WIDTH-1:0] d_i,
  input  logic             en_i,
  input  logic             sclr_i,
  input  logic             sset_i,
  input  logic             sload_i,
  output logic [WIDTH-1:0] nxt_o
);
  logic [WIDTH-1:0] preset;
  logic [WIDTH-1:0] plain;

  generate
    if (SSET_HAS_VAL) begin : g_const
      assign preset = SSET_VAL;
    end else begin : g_ones
      assign preset = '1;
    end
    if (KIND == FF_T) begin : g_tff
      assign plain = q_i ^ d_i;
    end else begin : g_dff
      assign plain = d_i;
    end
  endgenerate

  // enable gates everything; clear > set > load > plain
  always_comb begin
    if (!en_i)        nxt_o = q_i;
    else if (sclr_i)  nxt_o = '0;
    else if (sset_i)  nxt_o = preset;
    else if (sload_i) nxt_o = d_i;
    else              nxt_o = plain;
  end
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import ctl_reg_pkg::*;
#(
  parameter int unsigned       WIDTH        = 8,
  parameter ff_kind_e          KIND         = FF_D,
  parameter bit                ASET_HAS_VAL = 1'b0,
  parameter logic [WIDTH-1:0]  ASET_VAL     = '0,
  parameter bit                SSET_HAS_VAL = 1'b0,
  parameter logic [WIDTH-1:0]  SSET_VAL     = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [WIDTH-1:0] d_i,
  input  logic             aclr_i,
  input  logic             aset_i,
  input  logic             aload_i,
  input  logic             sclr_i,
  input  logic             sset_i,
  input  logic             sload_i,
  output logic [WIDTH-1:0] q_o
);
  localparam logic [WIDTH-1:0] SSET_EFF = SSET_HAS_VAL ? SSET_VAL : '1;
  localparam logic [WIDTH-1:0] ASET_EFF = ASET_HAS_VAL ? ASET_VAL : '1;

  logic [WIDTH-1:0] q_reg;
  logic [WIDTH-1:0] sync_nxt;
  logic [WIDTH-1:0] async_val;
  logic             async_on;

  ctl_reg_async #(
    .WIDTH(WIDTH), .ASET_HAS_VAL(ASET_HAS_VAL), .ASET_VAL(ASET_VAL)
  ) u_async (
    .aclr_i(aclr_i), .aset_i(aset_i), .aload_i(aload_i), .d_i(d_i),
    .active_o(async_on), .val_o(async_val)
  );

  ctl_reg_next #(
    .WIDTH(WIDTH), .KIND(KIND), .SSET_HAS_VAL(SSET_HAS_VAL), .SSET_VAL(SSET_VAL)
  ) u_next (
    .q_i(q_reg), .d_i(d_i), .en_i(en_i),
    .sclr_i(sclr_i), .sset_i(sset_i), .sload_i(sload_i),
    .nxt_o(sync_nxt)
  );

  // async value captured at the edge so it survives release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_reg <= '0;
    else if (async_on) q_reg <= async_val;
    else               q_reg <= sync_nxt;
  end

  always_comb begin
    if (!rst_ni)       q_o = '0;
    else if (async_on) q_o = async_val;
    else               q_o = q_reg;
  end

  // R7
  aclr_dom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aclr_i |-> q_o == '0);
  // R8
  aset_dom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aset_i && !aclr_i) |-> q_o == ASET_EFF);
  // R9
  aload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aload_i && !aset_i && !aclr_i) |-> q_o == d_i);
  // R10
  async_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (async_on && !en_i) |=> (aclr_i || aset_i || aload_i || q_o == $past(q_o)));
  // R3
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !async_on) |=> (aclr_i || aset_i || aload_i || q_o == $past(q_o)));
  // R4
  sclr_dom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sclr_i && !async_on) |=> (aclr_i || aset_i || aload_i || q_o == '0));
  // R5
  sset_dom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sset_i && !sclr_i && !async_on)
      |=> (aclr_i || aset_i || aload_i || q_o == SSET_EFF));
  // R6
  sload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sload_i && !sset_i && !sclr_i && !async_on)
      |=> (aclr_i || aset_i || aload_i || q_o == $past(d_i)));

  generate
    if (KIND == FF_T) begin : g_tchk
      // R2
      toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !sclr_i && !sset_i && !sload_i && !async_on)
          |=> (aclr_i || aset_i || aload_i || q_o == ($past(q_o) ^ $past(d_i))));
    end else begin : g_dchk
      // R1
      dload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !sclr_i && !sset_i && !sload_i && !async_on)
          |=> (aclr_i || aset_i || aload_i || q_o == $past(d_i)));
    end
  endgenerate
endmodule

// File: tb/ctl_reg_bank_test.sv
module ctl_reg_bank_test;
  import ctl_reg_pkg::*;

  localparam int W = 8;
  localparam logic [W-1:0] AV = 8'hA5;
  localparam logic [W-1:0] SV = 8'h3C;

  typedef struct {
    logic [W-1:0] qd;
    logic [W-1:0] qt;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b1;
  logic [W-1:0] d = '0;
  logic aclr = 0, aset = 0, aload = 0, sclr = 0, sset = 0, sload = 0;
  logic [W-1:0] qd, qt;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [W-1:0] md = '0, mt = '0;
  exp_t sb[$];

  always #2 clk = ~clk;

  ctl_reg_bank #(.WIDTH(W), .KIND(FF_D), .ASET_HAS_VAL(1'b1), .ASET_VAL(AV),
                 .SSET_HAS_VAL(1'b1), .SSET_VAL(SV)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .d_i(d),
    .aclr_i(aclr), .aset_i(aset), .aload_i(aload),
    .sclr_i(sclr), .sset_i(sset), .sload_i(sload), .q_o(qd));

  ctl_reg_bank #(.WIDTH(W), .KIND(FF_T)) uut_t (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .d_i(d),
    .aclr_i(aclr), .aset_i(aset), .aload_i(aload),
    .sclr_i(sclr), .sset_i(sset), .sload_i(sload), .q_o(qt));

  task automatic cmp(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] sync_model(input logic [W-1:0] q, input bit tff,
                                               input logic [W-1:0] sval);
    if (!en) return q;
    if (sclr) return '0;
    if (sset) return sval;
    if (sload) return d;
    return tff ? (q ^ d) : d;
  endfunction

  // driver: apply at falling edge, push expected post-edge value
  task automatic step(input logic [W-1:0] dv, input logic e,
                      input logic sc, input logic ss, input logic sl,
                      input logic ac, input logic as, input logic al,
                      input string tag);
    exp_t it;
    @(negedge clk);
    d = dv; en = e; sclr = sc; sset = ss; sload = sl;
    aclr = ac; aset = as; aload = al;
    if (ac || as || al) begin
      md = ac ? '0 : as ? AV : dv;
      mt = ac ? '0 : as ? '1 : dv;
      #1;
      cmp(qd, md, {tag, " immediate D"});
      cmp(qt, mt, {tag, " immediate T"});
    end else begin
      md = sync_model(md, 1'b0, SV);
      mt = sync_model(mt, 1'b1, '1);
    end
    it.qd = md; it.qt = mt; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input string tag);
    step(8'h00, 1'b0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (rst_ni && sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      cmp(qd, it.qd, {it.tag, " D"});
      cmp(qt, it.qt, {it.tag, " T"});
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    d = 8'hFF; sset = 1; // R11: ignored during reset
    #1;
    cmp(qd, '0, "R11 reset D");
    cmp(qt, '0, "R11 reset T");
    @(negedge clk);
    sset = 0; d = '0;
    rst_ni = 1;

    // R1 / R2 basic
    step(8'h5A, 1, 0, 0, 0, 0, 0, 0, "R1 R2 data/toggle");
    step(8'h0F, 1, 0, 0, 0, 0, 0, 0, "R1 R2 data/toggle 2");
    step(8'hF0, 1, 0, 0, 0, 0, 0, 0, "R1 R2 data/toggle 3");
    // R3 enable low ignores sync controls
    step(8'hFF, 0, 0, 0, 0, 0, 0, 0, "R3 hold plain");
    step(8'hFF, 0, 1, 0, 0, 0, 0, 0, "R3 hold sclr");
    step(8'h11, 0, 0, 1, 1, 0, 0, 0, "R3 hold sset sload");
    // R6 sload (toggle bank loads, not toggles)
    step(8'h96, 1, 0, 0, 1, 0, 0, 0, "R6 sload");
    // R4 sclr dominance
    step(8'h77, 1, 1, 1, 1, 0, 0, 0, "R4 sclr over sset sload");
    step(8'h77, 1, 1, 0, 0, 0, 0, 0, "R4 sclr alone");
    // R5 sset: constant on D bank, all ones on T bank
    step(8'h81, 1, 0, 1, 1, 0, 0, 0, "R5 sset over sload");
    step(8'h81, 1, 0, 1, 0, 0, 0, 0, "R5 sset alone");
    // R9 aload
    step(8'h24, 0, 0, 0, 0, 0, 0, 1, "R9 aload");
    idle("R10 keep after aload");
    // R8 aset over aload and sync controls
    step(8'h42, 1, 1, 0, 0, 0, 1, 1, "R8 aset over aload");
    idle("R10 keep after aset");
    // R7 aclr over aset and aload
    step(8'hEE, 1, 0, 1, 1, 1, 1, 1, "R7 aclr over all");
    idle("R10 keep after aclr");
    step(8'hEE, 1, 0, 0, 0, 1, 1, 0, "R7 aclr over aset");
    step(8'h3E, 1, 1, 1, 1, 0, 0, 1, "R10 aload over sync");
    step(8'h00, 1, 0, 0, 0, 0, 0, 0, "R10 release then clock");
    // R2 random toggle masks
    for (int i = 0; i < 40; i++) begin
      step(W'($urandom), 1, 0, 0, 0, 0, 0, 0, "R2 random toggle");
      if (i % 7 == 3) step(W'($urandom), 1, 0, 0, 1, 0, 0, 0, "R6 random load");
    end
    idle("R3 final hold");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule